// File: doc/BRIEF.md
# Exception Cause Register with Interval Timer

This block holds the exception cause word of a processor core. It also holds a free-running cycle counter with a match register, and it records the state of the core when an exception is taken. Hardware interrupt sources post level changes one line at a time through a numbered request port. Software updates the cause word, the counter and the match value through a single write port, with a select code. The pipeline pulses an entry strobe when it takes an exception. The strobe carries the exception code, a coprocessor number, whether the faulting instruction sat in a branch delay slot, its PC, and the current exception-level flag.

The block returns the cause word, the saved exception PC and the counter value. It also returns a vector of pending interrupts, already masked by the interrupt mask and enable bits from the status word. A static release-level input selects the later architecture release, which enables two things: a timer-pending flag in the cause word, and a software-writable counter-stop bit.

Top module: `exc_cause_unit`

## Requirements
- R1: After reset the cause word, the saved PC and the counter read zero, and the match register holds all ones, so no timer match occurs early.
- R2: A request on line n (0 to 7) with level 1 sets cause bit 8+n, and with level 0 clears it. Request numbers 8 to 15 change nothing.
- R3: A software cause write (select 0) changes only bits 23, 22, 9 and 8. Bit 27 is also written, but only when the release-level input equals 1. All other bits keep their value.
- R4: If a hardware request and a software cause write hit the same cycle, the software value wins for bits 9:8. Bits 15:10 follow only the hardware request.
- R5: While cause bit 27 is clear, the counter grows by one on each clock. A count write (select 1) loads the written value instead.
- R6: While cause bit 27 is set, the counter holds its value and no timer match is raised.
- R7: At a clock edge where the counter equals the match register, cause bit 15 (line 7) is set. When the release-level input equals 1, bit 30 is set as well.
- R8: A match write (select 2) clears cause bits 15 and 30 at that edge, even when a match occurs in the same cycle.
- R9: Exception entry loads the 5-bit code into cause bits 6:2. Code 11 (coprocessor unusable) also loads the 2-bit coprocessor number into bits 29:28. Other codes, such as 12 (overflow), leave bits 29:28 unchanged.
- R10: Exception entry from a delay slot saves PC−4 and sets bit 31 if the exception-level input is 0; if that input is 1, bit 31 is left unchanged. Entry outside a delay slot saves PC and clears bit 31.
- R11: The pending vector equals cause bits 15:8 ANDed with the status mask when enable is 1 and both exception-level and error-level are 0; otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| relLevel | input | 3 | Static release level; value 1 selects the later release |
| irqReqValid | input | 1 | Hardware request strobe |
| irqReqNum | input | 4 | Requested line number |
| irqReqLevel | input | 1 | New level of that line |
| swWrEn | input | 1 | Software write strobe |
| swWrSel | input | 2 | 0 cause, 1 counter, 2 match register |
| swWrData | input | 32 | Software write data |
| excValid | input | 1 | Exception entry strobe |
| excCode | input | 5 | Exception code |
| excCopNum | input | 2 | Coprocessor number for code 11 |
| excDelaySlot | input | 1 | Faulting instruction sits in a delay slot |
| excPc | input | 32 | PC of faulting instruction |
| excExl | input | 1 | Exception level already set |
| statusIm | input | 8 | Interrupt mask bits |
| statusIe | input | 1 | Global interrupt enable |
| statusExl | input | 1 | Exception level |
| statusErl | input | 1 | Error level |
| causeOut | output | 32 | Cause word |
| epcOut | output | 32 | Saved exception PC |
| countOut | output | 32 | Counter value |
| irqPending | output | 8 | Masked pending interrupts |

## Verification
The bench builds the block with its default parameters: a 32-bit word, eight interrupt lines and a 4-bit request number. The request number is wider than the line count, so the out-of-range numbers 8 to 15 can be driven and shown to change nothing. With the full 32-bit counter and match register, the bench loads the counter a few cycles short of the match value. This puts a match, a same-cycle match write, and a match held back by the stop bit inside short windows, and it runs them under both release-level settings.

// File: rtl/exc_cause_pkg.sv
package exc_cause_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_IRQ   = 8;
  localparam int IRQ_NUM_W = 4;
  localparam int SW_IP_N   = 2;   // low IP bits software may write
  localparam int TIMER_LINE = NUM_IRQ - 1;

  // field positions inside the cause word
  localparam int POS_BD    = 31;
  localparam int POS_TI    = 30;
  localparam int POS_CE_LO = 28;
  localparam int POS_DC    = 27;
  localparam int POS_IV    = 23;
  localparam int POS_WP    = 22;
  localparam int POS_IP_LO = 8;
  localparam int POS_CODE_LO = 2;
  localparam int CODE_W    = 5;
  localparam int CE_W      = 2;

  localparam logic [2:0] REL_LATE = 3'd1;
  localparam logic [CODE_W-1:0] CODE_COP_UNUSABLE = 5'd11;

  typedef enum logic [1:0] {
    SEL_CAUSE   = 2'd0,
    SEL_COUNT   = 2'd1,
    SEL_COMPARE = 2'd2,
    SEL_NONE    = 2'd3
  } wrSel_e;

  typedef struct packed {
    logic                wrCause;
    logic                wrCount;
    logic                wrCompare;
    logic [NUM_IRQ-1:0]  hwSet;
    logic [NUM_IRQ-1:0]  hwClr;
    logic                timerHit;
    logic                relLate;
    logic                excEnter;
    logic [DATA_W-1:0]   causeMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/exc_cause_ctrl.sv
module exc_cause_ctrl
  import exc_cause_pkg::*;
#(
  parameter int NIRQ  = NUM_IRQ,
  parameter int NUM_W = IRQ_NUM_W
) (
  input  logic [2:0]       relLevel,
  input  logic             irqReqValid,
  input  logic [NUM_W-1:0] irqReqNum,
  input  logic             irqReqLevel,
  input  logic             swWrEn,
  input  logic [1:0]       swWrSel,
  input  logic             excValid,
  input  logic             dcBit,
  input  logic             countMatch,
  output ctrlStrobes_t     stb
);
  localparam logic [DATA_W-1:0] BASE_MASK =
    (DATA_W'(1) << POS_IV) | (DATA_W'(1) << POS_WP) |
    (DATA_W'((1 << SW_IP_N) - 1) << POS_IP_LO);

  always_comb begin
    stb           = '0;
    stb.relLate   = (relLevel == REL_LATE);
    stb.wrCause   = swWrEn && (wrSel_e'(swWrSel) == SEL_CAUSE);
    stb.wrCount   = swWrEn && (wrSel_e'(swWrSel) == SEL_COUNT);
    stb.wrCompare = swWrEn && (wrSel_e'(swWrSel) == SEL_COMPARE);
    stb.excEnter  = excValid;
    stb.timerHit  = countMatch && !dcBit;
    stb.causeMask = BASE_MASK | (stb.relLate ? (DATA_W'(1) << POS_DC) : '0);
    for (int i = 0; i < NIRQ; i++) begin
      if (irqReqValid && (irqReqNum == NUM_W'(i))) begin
        stb.hwSet[i] = irqReqLevel;
        stb.hwClr[i] = !irqReqLevel;
      end
    end
  end
endmodule

// File: rtl/exc_cause_dp.sv
module exc_cause_dp
  import exc_cause_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NIRQ = NUM_IRQ
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobes_t        stb,
  input  logic [DW-1:0]       swWrData,
  input  logic [CODE_W-1:0]   excCode,
  input  logic [CE_W-1:0]     excCopNum,
  input  logic                excDelaySlot,
  input  logic [DW-1:0]       excPc,
  input  logic                excExl,
  input  logic [NIRQ-1:0]     statusIm,
  input  logic                statusIe,
  input  logic                statusExl,
  input  logic                statusErl,
  output logic [DW-1:0]       causeOut,
  output logic [DW-1:0]       epcOut,
  output logic [DW-1:0]       countOut,
  output logic [NIRQ-1:0]     irqPending,
  output logic                dcBit,
  output logic                countMatch
);
  localparam int IP_HI = POS_IP_LO + NIRQ - 1;

  logic [DW-1:0]   causeQ, causeNext, epcQ, countQ, compareQ;
  logic [NIRQ-1:0] ipHw, ipNext, swIp;

  always_comb begin
    ipHw      = (causeQ[IP_HI:POS_IP_LO] | stb.hwSet) & ~stb.hwClr;
    causeNext = causeQ;
    if (stb.wrCause)
      causeNext = (causeQ & ~stb.causeMask) | (swWrData & stb.causeMask);
    swIp   = causeNext[IP_HI:POS_IP_LO];
    ipNext = ipHw;
    if (stb.wrCause) ipNext[SW_IP_N-1:0] = swIp[SW_IP_N-1:0];
    if (stb.timerHit) ipNext[NIRQ-1] = 1'b1;
    if (stb.wrCompare) ipNext[NIRQ-1] = 1'b0;
    causeNext[IP_HI:POS_IP_LO] = ipNext;
    if (stb.timerHit && stb.relLate) causeNext[POS_TI] = 1'b1;
    if (stb.wrCompare) causeNext[POS_TI] = 1'b0;
    if (stb.excEnter) begin
      causeNext[POS_CODE_LO +: CODE_W] = excCode;
      if (excCode == CODE_COP_UNUSABLE)
        causeNext[POS_CE_LO +: CE_W] = excCopNum;
      if (excDelaySlot) begin
        if (!excExl) causeNext[POS_BD] = 1'b1;
      end else begin
        causeNext[POS_BD] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      causeQ   <= '0;
      epcQ     <= '0;
      countQ   <= '0;
      compareQ <= '1;
    end else begin
      causeQ <= causeNext;
      if (stb.excEnter)
        epcQ <= excDelaySlot ? (excPc - DW'(4)) : excPc;
      if (stb.wrCount)
        countQ <= swWrData;
      else if (!causeQ[POS_DC])
        countQ <= countQ + DW'(1);
      if (stb.wrCompare)
        compareQ <= swWrData;
    end
  end

  assign causeOut   = causeQ;
  assign epcOut     = epcQ;
  assign countOut   = countQ;
  assign dcBit      = causeQ[POS_DC];
  assign countMatch = (countQ == compareQ);
  assign irqPending = (statusIe && !statusExl && !statusErl) ?
                      (causeQ[IP_HI:POS_IP_LO] & statusIm) : '0;
endmodule

// File: rtl/exc_cause_unit.sv
module exc_cause_unit
  import exc_cause_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int NIRQ  = NUM_IRQ,
  parameter int NUM_W = IRQ_NUM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        relLevel,
  input  logic              irqReqValid,
  input  logic [NUM_W-1:0]  irqReqNum,
  input  logic              irqReqLevel,
  input  logic              swWrEn,
  input  logic [1:0]        swWrSel,
  input  logic [DW-1:0]     swWrData,
  input  logic              excValid,
  input  logic [4:0]        excCode,
  input  logic [1:0]        excCopNum,
  input  logic              excDelaySlot,
  input  logic [DW-1:0]     excPc,
  input  logic              excExl,
  input  logic [NIRQ-1:0]   statusIm,
  input  logic              statusIe,
  input  logic              statusExl,
  input  logic              statusErl,
  output logic [DW-1:0]     causeOut,
  output logic [DW-1:0]     epcOut,
  output logic [DW-1:0]     countOut,
  output logic [NIRQ-1:0]   irqPending
);
  ctrlStrobes_t stb;
  logic dcBit, countMatch;

  exc_cause_ctrl #(.NIRQ(NIRQ), .NUM_W(NUM_W)) u_ctrl (
    .relLevel(relLevel), .irqReqValid(irqReqValid), .irqReqNum(irqReqNum),
    .irqReqLevel(irqReqLevel), .swWrEn(swWrEn), .swWrSel(swWrSel),
    .excValid(excValid), .dcBit(dcBit), .countMatch(countMatch), .stb(stb)
  );

  exc_cause_dp #(.DW(DW), .NIRQ(NIRQ)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .swWrData(swWrData),
    .excCode(excCode), .excCopNum(excCopNum), .excDelaySlot(excDelaySlot),
    .excPc(excPc), .excExl(excExl), .statusIm(statusIm), .statusIe(statusIe),
    .statusExl(statusExl), .statusErl(statusErl), .causeOut(causeOut),
    .epcOut(epcOut), .countOut(countOut), .irqPending(irqPending),
    .dcBit(dcBit), .countMatch(countMatch)
  );
endmodule

// File: rtl/exc_cause_unit_chk.sv
module exc_cause_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  relLevel,
  input logic        swWrEn,
  input logic [1:0]  swWrSel,
  input logic [31:0] swWrData,
  input logic        excValid,
  input logic        excDelaySlot,
  input logic        excExl,
  input logic [31:0] excPc,
  input logic [31:0] causeOut,
  input logic [31:0] epcOut,
  input logic [31:0] countOut
);
  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!causeOut[27] && !(swWrEn && swWrSel == 2'd1)) |=> countOut == $past(countOut) + 32'd1);
  // R5
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swWrEn && swWrSel == 2'd1) |=> countOut == $past(swWrData));
  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (causeOut[27] && !(swWrEn && swWrSel == 2'd1)) |=> $stable(countOut));
  // R8
  compare_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swWrEn && swWrSel == 2'd2) |=> (!causeOut[15] && !causeOut[30]));
  // R3
  dc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swWrEn && swWrSel == 2'd0 && relLevel != 3'd1) |=> causeOut[27] == $past(causeOut[27]));
  // R10
  epc_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid && !excDelaySlot) |=> (epcOut == $past(excPc) && !causeOut[31]));
  // R10
  bd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid && excDelaySlot && excExl) |=> causeOut[31] == $past(causeOut[31]));
endmodule

bind exc_cause_unit exc_cause_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .relLevel(relLevel), .swWrEn(swWrEn),
  .swWrSel(swWrSel), .swWrData(swWrData), .excValid(excValid),
  .excDelaySlot(excDelaySlot), .excExl(excExl), .excPc(excPc),
  .causeOut(causeOut), .epcOut(epcOut), .countOut(countOut)
);

// File: tb/exc_cause_unit_test.sv
module exc_cause_unit_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  relLevel = 3'd1;
  logic        irqReqValid = 1'b0;
  logic [3:0]  irqReqNum = '0;
  logic        irqReqLevel = 1'b0;
  logic        swWrEn = 1'b0;
  logic [1:0]  swWrSel = 2'd3;
  logic [31:0] swWrData = '0;
  logic        excValid = 1'b0;
  logic [4:0]  excCode = '0;
  logic [1:0]  excCopNum = '0;
  logic        excDelaySlot = 1'b0;
  logic [31:0] excPc = '0;
  logic        excExl = 1'b0;
  logic [7:0]  statusIm = '0;
  logic        statusIe = 1'b0;
  logic        statusExl = 1'b0;
  logic        statusErl = 1'b0;
  logic [31:0] causeOut, epcOut, countOut;
  logic [7:0]  irqPending;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  exc_cause_unit uut (
    .clk(clk), .rst_n(rst_n), .relLevel(relLevel), .irqReqValid(irqReqValid),
    .irqReqNum(irqReqNum), .irqReqLevel(irqReqLevel), .swWrEn(swWrEn),
    .swWrSel(swWrSel), .swWrData(swWrData), .excValid(excValid),
    .excCode(excCode), .excCopNum(excCopNum), .excDelaySlot(excDelaySlot),
    .excPc(excPc), .excExl(excExl), .statusIm(statusIm), .statusIe(statusIe),
    .statusExl(statusExl), .statusErl(statusErl), .causeOut(causeOut),
    .epcOut(epcOut), .countOut(countOut), .irqPending(irqPending)
  );

  // {kind, num, data, delaySlot, exl, expectedCause}; kind 0 request, 1 cause write, 2 exception
  localparam int NV = 11;
  localparam logic [71:0] VECS [NV] = '{
    {2'd0, 4'd3,  32'h0000_0001, 1'b0, 1'b0, 32'h0000_0800},  // R2
    {2'd0, 4'd9,  32'h0000_0001, 1'b0, 1'b0, 32'h0000_0800},  // R2
    {2'd1, 4'd0,  32'hFFFF_FFFF, 1'b0, 1'b0, 32'h08C0_0B00},  // R3
    {2'd1, 4'd0,  32'h0000_0000, 1'b0, 1'b0, 32'h0000_0800},  // R3
    {2'd2, 4'd0,  32'h0000_020B, 1'b0, 1'b0, 32'h2000_082C},  // R9
    {2'd2, 4'd0,  32'h0000_030C, 1'b1, 1'b0, 32'hA000_0830},  // R9 R10
    {2'd2, 4'd0,  32'h0000_000C, 1'b0, 1'b0, 32'h2000_0830},  // R10
    {2'd2, 4'd0,  32'h0000_000C, 1'b1, 1'b1, 32'h2000_0830},  // R10
    {2'd0, 4'd3,  32'h0000_0000, 1'b0, 1'b0, 32'h2000_0030},  // R2
    {2'd0, 4'd15, 32'h0000_0001, 1'b0, 1'b0, 32'h2000_0030},  // R2
    {2'd0, 4'd6,  32'h0000_0001, 1'b0, 1'b0, 32'h2000_4030}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    irqReqValid = 1'b0;
    swWrEn = 1'b0;
    excValid = 1'b0;
  endtask

  task automatic swWrite(input logic [1:0] sel, input logic [31:0] d);
    swWrEn = 1'b1; swWrSel = sel; swWrData = d;
    step();
  endtask

  task automatic exc(input logic [4:0] code, input logic [1:0] cop,
                     input logic ds, input logic exl, input logic [31:0] pc);
    excValid = 1'b1; excCode = code; excCopNum = cop;
    excDelaySlot = ds; excExl = exl; excPc = pc;
    step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 cause", causeOut, 32'h0);
    check("R1 epc", epcOut, 32'h0);
    check("R1 count", countOut, 32'h0);
    check("R1 pending", {24'h0, irqPending}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [71:0] v;
      v = VECS[i];
      case (v[71:70])
        2'd0: begin
          irqReqValid = 1'b1; irqReqNum = v[69:66]; irqReqLevel = v[34];
          step();
        end
        2'd1: swWrite(2'd0, v[65:34]);
        default: exc(v[38:34], v[43:42], v[33], v[32], 32'h0000_0100);
      endcase
      check($sformatf("R2/R3/R9/R10 vector %0d", i), causeOut, v[31:0]);
    end

    // R10 saved PC
    exc(5'd0, 2'd0, 1'b1, 1'b0, 32'h0000_1000);
    check("R10 epc delay slot", epcOut, 32'h0000_0FFC);
    check("R10 bd set", {31'h0, causeOut[31]}, 32'h1);
    exc(5'd0, 2'd0, 1'b0, 1'b0, 32'h0000_2000);
    check("R10 epc plain", epcOut, 32'h0000_2000);
    check("R10 bd clear", {31'h0, causeOut[31]}, 32'h0);

    // R4 same-cycle request and cause write
    irqReqValid = 1'b1; irqReqNum = 4'd0; irqReqLevel = 1'b1;
    swWrite(2'd0, 32'h0);
    check("R4 software wins low IP", {31'h0, causeOut[8]}, 32'h0);
    irqReqValid = 1'b1; irqReqNum = 4'd4; irqReqLevel = 1'b1;
    swWrite(2'd0, 32'h0);
    check("R4 hardware keeps IP4", {31'h0, causeOut[12]}, 32'h1);

    // R5 R7 R8 timer, later release
    relLevel = 3'd1;
    swWrite(2'd2, 32'd105);
    swWrite(2'd1, 32'd100);
    check("R5 count load", countOut, 32'd100);
    repeat (5) step();
    check("R5 count step", countOut, 32'd105);
    check("R7 no early match", {31'h0, causeOut[15]}, 32'h0);
    step();
    check("R7 match IP7", {31'h0, causeOut[15]}, 32'h1);
    check("R7 match TI", {31'h0, causeOut[30]}, 32'h1);
    swWrite(2'd2, 32'hFFFF_FFFF);
    check("R8 clear on match write", {30'h0, causeOut[30], causeOut[15]}, 32'h0);

    // R7 earlier release: no TI
    relLevel = 3'd0;
    swWrite(2'd2, 32'd205);
    swWrite(2'd1, 32'd200);
    repeat (6) step();
    check("R7 early release IP7", {31'h0, causeOut[15]}, 32'h1);
    check("R7 early release TI", {31'h0, causeOut[30]}, 32'h0);
    swWrite(2'd2, 32'hFFFF_FFFF);

    // R8 match write in the matching cycle
    swWrite(2'd2, 32'd302);
    swWrite(2'd1, 32'd300);
    repeat (2) step();
    swWrite(2'd2, 32'hFFFF_FFFF);
    check("R8 write beats match", {31'h0, causeOut[15]}, 32'h0);

    // R3 R6 stop bit
    swWrite(2'd0, 32'h0800_0000);
    check("R3 stop bit locked", {31'h0, causeOut[27]}, 32'h0);
    c0 = countOut;
    repeat (3) step();
    check("R5 count runs", countOut, c0 + 32'd3);
    relLevel = 3'd1;
    swWrite(2'd0, 32'h0800_0000);
    check("R3 stop bit written", {31'h0, causeOut[27]}, 32'h1);
    c0 = countOut;
    repeat (4) step();
    check("R6 count frozen", countOut, c0);
    swWrite(2'd2, c0);
    repeat (3) step();
    check("R6 no match while stopped", {31'h0, causeOut[15]}, 32'h0);
    swWrite(2'd0, 32'h0);
    check("R6 still frozen at release edge", countOut, c0);
    step();
    check("R7 match after release", {31'h0, causeOut[15]}, 32'h1);

    // R11 pending vector; IP holds lines 7, 6 and 4
    statusIm = 8'hFF; statusIe = 1'b1; #1;
    check("R11 all enabled", {24'h0, irqPending}, 32'h0000_00D0);
    statusIm = 8'h10; #1;
    check("R11 masked", {24'h0, irqPending}, 32'h0000_0010);
    statusExl = 1'b1; #1;
    check("R11 exl blocks", {24'h0, irqPending}, 32'h0);
    statusExl = 1'b0; statusErl = 1'b1; #1;
    check("R11 erl blocks", {24'h0, irqPending}, 32'h0);
    statusErl = 1'b0; statusIe = 1'b0; #1;
    check("R11 ie off", {24'h0, irqPending}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule